// File: doc/BRIEF.md
# UART Sleep and Wake Controller

This block decides when one UART channel may drop into a low-power sleep state and, while it sleeps, holds the enables for the channel's core clock and its baud-rate clock low. It runs on a free-running clock that is never gated. Sleep is armed by two control bits: an enhanced-functions enable and a sleep enable. Entry is then qualified by four things: the receive line is idle, the transmit path has drained, the receive FIFO is empty, and no interrupt is pending apart from two that are allowed to stay pending.

On entry the block captures the levels of the RX pin and the modem status pins. It wakes when any of those levels differs from its captured value, when the host writes into the transmit FIFO, or when software clears either enable bit. The clock enables come back in the same cycle as the wake cause. The sleep status itself clears at the next clock edge.

Divisor-latch writes are only valid while the channel is awake. A divisor write that arrives during sleep is blocked and raises a sticky violation flag.

Top module: `uart_sleep_ctl`

## Requirements
- R1: After reset `asleep` and `violation` are low, and `core_clk_en` and `baud_clk_en` are high.
- R2: `asleep` rises after the second of two consecutive rising edges at which the entry condition holds. A condition present at only one edge does not put the channel to sleep.
- R3: The entry condition needs all six of these to be high: `enh_en`, `slp_en`, `rx_idle`, `tx_fifo_empty`, `tx_shift_empty` and `rx_fifo_empty`. If any one of them is low, no sleep follows.
- R4: In `irq_pend`, bit 0 (transmit holding register empty) and bit 1 (receive timeout) do not block entry. Bit 2 or bit 3 set blocks entry.
- R5: While asleep and with no wake cause present, `core_clk_en` and `baud_clk_en` are both low and the channel stays asleep.
- R6: While asleep, an `rx_in` level that differs from its level at entry raises both clock enables in the same cycle, and `asleep` clears at the next edge.
- R7: While asleep, any `modem_in` bit that differs from its level at entry wakes the channel with the same timing as R6.
- R8: While asleep, a `tx_wr` pulse wakes the channel with the same timing as R6.
- R9: While asleep, clearing `enh_en` or `slp_en` wakes the channel with the same timing as R6.
- R10: `div_wr_apply` follows `div_wr` while awake and stays low while asleep. A `div_wr` during sleep sets `violation`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enh_en | input | 1 | Enhanced-functions enable |
| slp_en | input | 1 | Sleep enable |
| rx_idle | input | 1 | Receive line has been idle |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| irq_pend | input | NIRQ | Pending interrupt sources; bit 0 THR empty, bit 1 RX timeout |
| rx_in | input | 1 | Serial receive pin level |
| modem_in | input | NMODEM | Modem status pin levels |
| tx_wr | input | 1 | Host write strobe into the transmit FIFO |
| div_wr | input | 1 | Host divisor-latch write strobe |
| asleep | output | 1 | Channel is in sleep |
| core_clk_en | output | 1 | Enable for the UART core clock |
| baud_clk_en | output | 1 | Enable for the baud-rate clock |
| div_wr_apply | output | 1 | Divisor write allowed through |
| violation | output | 1 | Sticky flag: divisor write attempted while asleep |

## Verification
The assertions assume that every input is already synchronous to `clk`, so a pin change is seen as a clean level at one edge. They also assume the strobes last one cycle. The bench drives every input on the falling edge and holds the RX and modem levels steady through each entry sequence, so the captured levels are well defined. The sweep covers all 1024 combinations of the six qualifiers and four interrupt bits. A wake test is then run for each wake source against each of 32 captured pin patterns.

// File: rtl/uart_sleep_ctl.sv
module uart_sleep_ctl #(
  parameter int NMODEM = 4,
  parameter int NIRQ   = 4,
  parameter logic [NIRQ-1:0] IGN_MASK = {{(NIRQ-2){1'b0}}, 2'b11}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enh_en,
  input  logic              slp_en,
  input  logic              rx_idle,
  input  logic              tx_fifo_empty,
  input  logic              tx_shift_empty,
  input  logic              rx_fifo_empty,
  input  logic [NIRQ-1:0]   irq_pend,
  input  logic              rx_in,
  input  logic [NMODEM-1:0] modem_in,
  input  logic              tx_wr,
  input  logic              div_wr,
  output logic              asleep,
  output logic              core_clk_en,
  output logic              baud_clk_en,
  output logic              div_wr_apply,
  output logic              violation
);

  logic qual, qual_q, asleep_q, wake, viol_q, rx_snap;
  logic [NMODEM-1:0] mdm_snap;

  assign qual = enh_en & slp_en & rx_idle & tx_fifo_empty & tx_shift_empty
              & rx_fifo_empty & ~|(irq_pend & ~IGN_MASK);

  assign wake = asleep_q & (~enh_en | ~slp_en | tx_wr
              | (rx_in != rx_snap) | (modem_in != mdm_snap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q   <= 1'b0;
      asleep_q <= 1'b0;
      rx_snap  <= 1'b0;
      mdm_snap <= '0;
      viol_q   <= 1'b0;
    end else begin
      if (asleep_q) begin
        qual_q <= 1'b0;
        if (wake) asleep_q <= 1'b0;
      end else begin
        qual_q <= qual;
        if (qual && qual_q) begin
          asleep_q <= 1'b1;
          rx_snap  <= rx_in;
          mdm_snap <= modem_in;
        end
      end
      if (div_wr && asleep_q) viol_q <= 1'b1;
    end
  end

  assign asleep       = asleep_q;
  assign core_clk_en  = ~asleep_q | wake;
  assign baud_clk_en  = ~asleep_q | wake;
  assign div_wr_apply = div_wr & ~asleep_q;
  assign violation    = viol_q;

  // R2
  two_cycle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> ($past(enh_en && slp_en, 2) && $past(enh_en && slp_en)));

  // R3
  entry_conditions_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(rx_idle && tx_fifo_empty && tx_shift_empty && rx_fifo_empty));

  // R4
  irq_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past((irq_pend & ~IGN_MASK) == '0));

  // R8
  tx_write_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && tx_wr) |=> !asleep);

  // R9
  enable_clear_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !(enh_en && slp_en)) |=> !asleep);

  // R10
  violation_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  // R10
  violation_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation) |-> $past(asleep && div_wr));

endmodule

// File: tb/uart_sleep_ctl_test.sv
`timescale 1ns/100ps
module uart_sleep_ctl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enh_en, slp_en, rx_idle, tx_fifo_empty, tx_shift_empty, rx_fifo_empty;
  logic [3:0] irq_pend;
  logic rx_in;
  logic [3:0] modem_in;
  logic tx_wr, div_wr;
  logic asleep, core_clk_en, baud_clk_en, div_wr_apply, violation;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_sleep_ctl uut (
    .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .slp_en(slp_en),
    .rx_idle(rx_idle), .tx_fifo_empty(tx_fifo_empty),
    .tx_shift_empty(tx_shift_empty), .rx_fifo_empty(rx_fifo_empty),
    .irq_pend(irq_pend), .rx_in(rx_in), .modem_in(modem_in),
    .tx_wr(tx_wr), .div_wr(div_wr), .asleep(asleep),
    .core_clk_en(core_clk_en), .baud_clk_en(baud_clk_en),
    .div_wr_apply(div_wr_apply), .violation(violation)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic all_ok();
    enh_en = 1; slp_en = 1; rx_idle = 1; tx_fifo_empty = 1;
    tx_shift_empty = 1; rx_fifo_empty = 1; irq_pend = 4'b0000;
    tx_wr = 0; div_wr = 0;
  endtask

  task automatic park();
    @(negedge clk);
    all_ok(); slp_en = 0;
    @(negedge clk);
  endtask

  task automatic go_sleep(input logic [4:0] pat);
    park();
    rx_in = pat[0]; modem_in = pat[4:1];
    all_ok();
    @(negedge clk);
    @(negedge clk);
    check("R2", asleep, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    all_ok(); slp_en = 0; rx_in = 1; modem_in = 4'b0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1", asleep, 1'b0);
    check("R1", violation, 1'b0);
    check("R1", core_clk_en, 1'b1);
    check("R1", baud_clk_en, 1'b1);

    // R2 R3 R4: sweep of qualifier and interrupt combinations
    for (int c = 0; c < 1024; c++) begin
      logic [9:0] v;
      logic exp;
      v = c[9:0];
      park();
      enh_en = v[0]; slp_en = v[1]; rx_idle = v[2]; tx_fifo_empty = v[3];
      tx_shift_empty = v[4]; rx_fifo_empty = v[5]; irq_pend = v[9:6];
      exp = (&v[5:0]) && (v[9:8] == 2'b00);
      @(negedge clk);
      check("R2", asleep, 1'b0);
      @(negedge clk);
      if (&v[5:0]) check("R4", asleep, exp);
      else         check("R3", asleep, exp);
      if (exp) begin
        check("R5", core_clk_en, 1'b0);
        check("R5", baud_clk_en, 1'b0);
      end
    end

    // R2: a condition broken after one edge does not sleep
    park();
    all_ok();
    @(negedge clk);
    rx_idle = 0;
    @(negedge clk);
    rx_idle = 1;
    @(negedge clk);
    check("R2", asleep, 1'b0);

    // R5 R6 R7 R8: each wake source against each captured pin pattern
    for (int src = 0; src < 6; src++) begin
      for (int p = 0; p < 32; p++) begin
        logic [4:0] pat;
        pat = p[4:0];
        go_sleep(pat);
        @(negedge clk);
        check("R5", asleep, 1'b1);
        check("R5", core_clk_en, 1'b0);
        check("R5", baud_clk_en, 1'b0);
        if (src == 0) rx_in = ~rx_in;
        else if (src == 5) tx_wr = 1;
        else modem_in[src-1] = ~modem_in[src-1];
        #1;
        if (src == 0) begin
          check("R6", core_clk_en, 1'b1); check("R6", baud_clk_en, 1'b1);
        end else if (src == 5) begin
          check("R8", core_clk_en, 1'b1); check("R8", baud_clk_en, 1'b1);
        end else begin
          check("R7", core_clk_en, 1'b1); check("R7", baud_clk_en, 1'b1);
        end
        @(negedge clk);
        tx_wr = 0;
        if (src == 0) check("R6", asleep, 1'b0);
        else if (src == 5) check("R8", asleep, 1'b0);
        else check("R7", asleep, 1'b0);
      end
    end

    // R9: clearing either enable bit wakes
    for (int k = 0; k < 2; k++) begin
      go_sleep(5'b00001);
      if (k == 0) enh_en = 0; else slp_en = 0;
      #1;
      check("R9", core_clk_en, 1'b1);
      @(negedge clk);
      check("R9", asleep, 1'b0);
    end

    // R10: divisor writes
    park();
    div_wr = 1;
    #1;
    check("R10", div_wr_apply, 1'b1);
    @(negedge clk);
    div_wr = 0;
    check("R10", violation, 1'b0);
    go_sleep(5'b10101);
    div_wr = 1;
    #1;
    check("R10", div_wr_apply, 1'b0);
    @(negedge clk);
    div_wr = 0;
    check("R10", violation, 1'b1);
    check("R10", asleep, 1'b1);
    park();
    @(negedge clk);
    check("R10", violation, 1'b1);
    div_wr = 1;
    #1;
    check("R10", div_wr_apply, 1'b1);
    @(negedge clk);
    div_wr = 0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule